// File: doc/BRIEF.md
# Two-Slot Flow Table Allocator

This block owns a flow table held in on-chip storage. Each slot holds a control word (a static flag, a two-bit lifecycle state and a timestamp) and a data payload. A forwarding engine reads slots through a lookup port. Software, or a neighbouring block, hands the allocator commit requests that carry a finished entry and a precomputed hash index. The allocator tries the hashed slot first and then the slot right after it. It writes the entry into the first slot that is free to take. It then answers with the chosen index, or with a no-space status, and pulses a cache-clear strobe so that any cached copy of the table is dropped.

There are two sweep commands, and each visits one slot per cycle while `busy` is high. The initialise sweep runs by itself after reset and can also be issued on demand. It clears every control word and payload, marks a fixed set of reserved slots in every 128-slot group as static, and sets the global enable once it finishes. The stop sweep drops the global enable when the command is accepted and returns every control word to INVALID. Payloads are left as they are. A caller waiting on stop polls `busy` until it falls.

Control is one state machine. Its states are IDLE, INIT (initialise sweep), STOP (stop sweep), PROBE0 (test the hashed slot), PROBE1 (test the next slot), WDATA (write payload), WCTRL (write control word), CLR (cache-clear pulse) and RESP (response). The transitions are as follows. IDLE goes to PROBE0, STOP or INIT when a command is accepted. INIT and STOP go back to IDLE after the last slot. PROBE0 goes to WDATA if the hashed slot is usable, otherwise to PROBE1. PROBE1 goes to WDATA if the next slot is usable, otherwise straight to RESP. After that the path runs WDATA, WCTRL, CLR, RESP and back to IDLE. Reset enters INIT.

Top module: `flow_slot_alloc`

## Requirements
- R1: After reset release, or after an accepted initialise command (`cmd_op`=2), `busy` stays high for exactly 2^IDX_W cycles. At the end every payload is zero and every control word has state INVALID and timestamp zero. `glob_en` is set when the sweep ends.
- R2: With RESERVE_EN set, the initialise sweep sets the static flag (control bit TS_W+2) on the slots whose index modulo 128 is 12, 25, 38, 51, 76, 89 or 102, and clears it on all other slots.
- R3: A slot is usable only if its static flag is clear and its state (control bits TS_W+1:TS_W) is not BIND. The state codes are 0 INVALID, 1 UNBIND, 2 BIND and 3 FIN. An UNBIND or FIN slot may be overwritten.
- R4: A commit (`cmd_op`=0) first tests slot `hash`, then slot (`hash`+1) modulo 2^IDX_W, and stores into the first usable one. `rsp_valid` rises 5 cycles after the accepting edge when the hashed slot is used and 6 cycles after it when the next slot is used, with `rsp_ok`=1 and `rsp_idx` set to the chosen slot.
- R5: If neither slot is usable, `rsp_valid` rises 3 cycles after the accepting edge with `rsp_ok`=0 and `rsp_idx`=`hash`, and the table is not changed.
- R6: The stored control word is {static=0, `cmd_state`, `cmd_ts` masked to its low TS_W bits}, and the stored payload is `cmd_data`.
- R7: The payload is written one cycle before the control word. The lookup port shows the new payload alongside the old control word for one cycle.
- R8: `cache_clr` is a one-cycle pulse in the cycle just before `rsp_valid`, and only for a successful commit.
- R9: An accepted stop (`cmd_op`=1) clears `glob_en` at once and keeps `busy` high for 2^IDX_W cycles. It leaves every control word all-zero (INVALID, not static) and keeps every payload.
- R10: `cmd_ready` is high only when the block is idle, and a request held on `cmd_valid` while busy has no effect. `busy` drops in the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the initialise sweep |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted on this edge when high with cmd_valid |
| cmd_op | input | 2 | 0 commit, 1 stop, 2 initialise, 3 ignored |
| cmd_hash | input | IDX_W | Hashed slot index of a commit |
| cmd_ts | input | TS_IN_W | Timestamp, masked to TS_W bits |
| cmd_state | input | 2 | State code of the entry being committed |
| cmd_data | input | DATA_W | Payload of the entry being committed |
| rsp_valid | output | 1 | One-cycle commit response |
| rsp_ok | output | 1 | 1 stored, 0 no space |
| rsp_idx | output | IDX_W | Chosen slot, or the hash on failure |
| cache_clr | output | 1 | Cache-clear pulse after a successful commit |
| busy | output | 1 | High while a sweep or commit is in progress |
| glob_en | output | 1 | Global enable for the table's users |
| lk_idx | input | IDX_W | Lookup slot index |
| lk_ctrl | output | TS_W+3 | Control word of the looked-up slot |
| lk_data | output | DATA_W | Payload of the looked-up slot |

## Verification
The bench drives several kinds of commit. One hits a free slot. One collides and falls back to the next slot. One finds both slots bound. One lands just before a reserved slot, one overwrites an UNBIND slot, and one hashes to the last index so that the probe wraps to slot 0. A design that tests only one slot, or wraps wrongly, returns the wrong index or a false no-space. A design that ignores the static flag hands out a reserved slot. A design that writes the control word first shows a bound slot with a stale payload in the WCTRL cycle. The bench also holds a stop request on the port during a commit, which catches a design that accepts while busy. It checks that stop keeps payloads but clears static flags, so a design that confuses the two sweeps fails the full-table comparison.

// File: rtl/flow_alloc_pkg.sv
package flow_alloc_pkg;

    typedef enum logic [1:0] {
        ST_INVALID = 2'd0,
        ST_UNBIND  = 2'd1,
        ST_BIND    = 2'd2,
        ST_FIN     = 2'd3
    } flow_state_e;

    typedef enum logic [1:0] {
        OP_COMMIT = 2'd0,
        OP_STOP   = 2'd1,
        OP_INIT   = 2'd2,
        OP_NONE   = 2'd3
    } flow_op_e;

    typedef enum logic [3:0] {
        F_IDLE,
        F_INIT,
        F_STOP,
        F_PROBE0,
        F_PROBE1,
        F_WDATA,
        F_WCTRL,
        F_CLR,
        F_RESP
    } fsm_state_e;

    localparam int GROUP_SIZE = 128;

endpackage

// File: rtl/flow_table_mem.sv
module flow_table_mem #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 13
) (
    input  logic              clk,
    input  logic              ctrl_we,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [CTRL_W-1:0] wctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  p_addr,
    output logic [2:0]        p_flags,
    input  logic [IDX_W-1:0]  l_addr,
    output logic [CTRL_W-1:0] l_ctrl,
    output logic [DATA_W-1:0] l_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CTRL_W-1:0] ctrl_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ctrl_we) ctrl_q[waddr] <= wctrl;
        if (data_we) data_q[waddr] <= wdata;
    end

    assign p_flags = ctrl_q[p_addr][CTRL_W-1 -: 3];
    assign l_ctrl  = ctrl_q[l_addr];
    assign l_data  = data_q[l_addr];

endmodule

// File: rtl/flow_reserve_map.sv
module flow_reserve_map
    import flow_alloc_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter bit RESERVE_EN = 1'b1
) (
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    localparam logic [IDX_W-1:0] OFF_MASK = IDX_W'(GROUP_SIZE - 1);

    generate
        if (RESERVE_EN) begin : g_res
            logic [IDX_W-1:0] off;
            assign off = idx & OFF_MASK;
            assign hit = (off == IDX_W'(12)) || (off == IDX_W'(25)) ||
                         (off == IDX_W'(38)) || (off == IDX_W'(51)) ||
                         (off == IDX_W'(76)) || (off == IDX_W'(89)) ||
                         (off == IDX_W'(102));
        end else begin : g_nores
            logic [IDX_W-1:0] unused_idx;
            assign unused_idx = idx;
            assign hit = 1'b0 & (|unused_idx);
        end
    endgenerate

endmodule

// File: rtl/flow_alloc_fsm.sv
module flow_alloc_fsm
    import flow_alloc_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 32,
    parameter int TS_W    = 10,
    parameter int TS_IN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [1:0]          cmd_op,
    input  logic [IDX_W-1:0]    cmd_hash,
    input  logic [TS_IN_W-1:0]  cmd_ts,
    input  logic [1:0]          cmd_state,
    input  logic [DATA_W-1:0]   cmd_data,
    output logic [IDX_W-1:0]    probe_addr,
    input  logic [2:0]          probe_flags,
    output logic [IDX_W-1:0]    res_addr,
    input  logic                res_hit,
    output logic                ctrl_we,
    output logic                data_we,
    output logic [IDX_W-1:0]    waddr,
    output logic [TS_W+2:0]     wctrl,
    output logic [DATA_W-1:0]   wdata,
    output logic                rsp_valid,
    output logic                rsp_ok,
    output logic [IDX_W-1:0]    rsp_idx,
    output logic                cache_clr,
    output logic                busy,
    output logic                glob_en
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    fsm_state_e          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    sel_q;
    logic [TS_W-1:0]     ts_q;
    logic [1:0]          st_q;
    logic [DATA_W-1:0]   dat_q;
    logic                ok_q;
    logic                glob_q;
    logic                usable;
    logic                sweep_last;

    assign usable     = !probe_flags[2] && (probe_flags[1:0] != ST_BIND);
    assign sweep_last = (idx_q == LAST_IDX);
    assign probe_addr = (state_q == F_PROBE1) ? idx_q + 1'b1 : idx_q;
    assign res_addr   = idx_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_IDLE: begin
                if (cmd_valid) begin
                    unique case (flow_op_e'(cmd_op))
                        OP_COMMIT: state_d = F_PROBE0;
                        OP_STOP:   state_d = F_STOP;
                        OP_INIT:   state_d = F_INIT;
                        default:   state_d = F_IDLE;
                    endcase
                end
            end
            F_INIT, F_STOP: if (sweep_last) state_d = F_IDLE;
            F_PROBE0: state_d = usable ? F_WDATA : F_PROBE1;
            F_PROBE1: state_d = usable ? F_WDATA : F_RESP;
            F_WDATA:  state_d = F_WCTRL;
            F_WCTRL:  state_d = F_CLR;
            F_CLR:    state_d = F_RESP;
            F_RESP:   state_d = F_IDLE;
            default:  state_d = F_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= F_INIT;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            sel_q  <= '0;
            ts_q   <= '0;
            st_q   <= '0;
            dat_q  <= '0;
            ok_q   <= 1'b0;
            glob_q <= 1'b0;
        end else begin
            unique case (state_q)
                F_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_op == OP_COMMIT) begin
                            idx_q <= cmd_hash;
                            sel_q <= cmd_hash;
                            ts_q  <= TS_W'(cmd_ts);
                            st_q  <= cmd_state;
                            dat_q <= cmd_data;
                            ok_q  <= 1'b0;
                        end else if (cmd_op == OP_STOP) begin
                            idx_q  <= '0;
                            glob_q <= 1'b0;
                        end else if (cmd_op == OP_INIT) begin
                            idx_q <= '0;
                        end
                    end
                end
                F_INIT: begin
                    idx_q <= idx_q + 1'b1;
                    if (sweep_last) glob_q <= 1'b1;
                end
                F_STOP: idx_q <= idx_q + 1'b1;
                F_PROBE0: begin
                    if (usable) begin
                        sel_q <= idx_q;
                        ok_q  <= 1'b1;
                    end
                end
                F_PROBE1: begin
                    if (usable) begin
                        sel_q <= idx_q + 1'b1;
                        ok_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        ctrl_we   = 1'b0;
        data_we   = 1'b0;
        waddr     = sel_q;
        wctrl     = {1'b0, st_q, ts_q};
        wdata     = dat_q;
        cache_clr = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            F_IDLE:  cmd_ready = 1'b1;
            F_INIT: begin
                ctrl_we = 1'b1;
                data_we = 1'b1;
                waddr   = idx_q;
                wctrl   = {res_hit, ST_INVALID, {TS_W{1'b0}}};
                wdata   = '0;
            end
            F_STOP: begin
                ctrl_we = 1'b1;
                waddr   = idx_q;
                wctrl   = '0;
            end
            F_WDATA: data_we   = 1'b1;
            F_WCTRL: ctrl_we   = 1'b1;
            F_CLR:   cache_clr = 1'b1;
            F_RESP:  rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign busy    = (state_q != F_IDLE);
    assign rsp_ok  = ok_q;
    assign rsp_idx = sel_q;
    assign glob_en = glob_q;

    // R8
    clr_then_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cache_clr |=> (rsp_valid && rsp_ok));

    // R5
    fail_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> !$past(cache_clr));

    // R7
    data_before_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == F_WCTRL) |-> ($past(data_we) && ($past(waddr) == waddr)));

    // R4
    probe_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> ((rsp_idx == idx_q) || (rsp_idx == idx_q + 1'b1)));

    // R10
    resp_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> cmd_ready);

    // R9
    stop_drop_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glob_en) |-> ((state_q == F_STOP) && (idx_q == '0)));

    // R1
    init_done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glob_en) |-> (cmd_ready && $past(state_q == F_INIT)));

endmodule

// File: rtl/flow_slot_alloc.sv
module flow_slot_alloc
    import flow_alloc_pkg::*;
#(
    parameter int IDX_W      = 8,
    parameter int DATA_W     = 32,
    parameter int TS_W       = 10,
    parameter int TS_IN_W    = 16,
    parameter bit RESERVE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_hash,
    input  logic [TS_IN_W-1:0] cmd_ts,
    input  logic [1:0]         cmd_state,
    input  logic [DATA_W-1:0]  cmd_data,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic [IDX_W-1:0]   rsp_idx,
    output logic               cache_clr,
    output logic               busy,
    output logic               glob_en,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic [TS_W+2:0]    lk_ctrl,
    output logic [DATA_W-1:0]  lk_data
);
    localparam int CTRL_W = TS_W + 3;

    logic [IDX_W-1:0]  probe_addr;
    logic [2:0]        probe_flags;
    logic [IDX_W-1:0]  res_addr;
    logic              res_hit;
    logic              ctrl_we;
    logic              data_we;
    logic [IDX_W-1:0]  waddr;
    logic [CTRL_W-1:0] wctrl;
    logic [DATA_W-1:0] wdata;

    flow_alloc_fsm #(
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W),
        .TS_W    (TS_W),
        .TS_IN_W (TS_IN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_hash    (cmd_hash),
        .cmd_ts      (cmd_ts),
        .cmd_state   (cmd_state),
        .cmd_data    (cmd_data),
        .probe_addr  (probe_addr),
        .probe_flags (probe_flags),
        .res_addr    (res_addr),
        .res_hit     (res_hit),
        .ctrl_we     (ctrl_we),
        .data_we     (data_we),
        .waddr       (waddr),
        .wctrl       (wctrl),
        .wdata       (wdata),
        .rsp_valid   (rsp_valid),
        .rsp_ok      (rsp_ok),
        .rsp_idx     (rsp_idx),
        .cache_clr   (cache_clr),
        .busy        (busy),
        .glob_en     (glob_en)
    );

    flow_reserve_map #(
        .IDX_W      (IDX_W),
        .RESERVE_EN (RESERVE_EN)
    ) u_resmap (
        .idx (res_addr),
        .hit (res_hit)
    );

    flow_table_mem #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W)
    ) u_mem (
        .clk     (clk),
        .ctrl_we (ctrl_we),
        .data_we (data_we),
        .waddr   (waddr),
        .wctrl   (wctrl),
        .wdata   (wdata),
        .p_addr  (probe_addr),
        .p_flags (probe_flags),
        .l_addr  (lk_idx),
        .l_ctrl  (lk_ctrl),
        .l_data  (lk_data)
    );

endmodule

// File: tb/flow_slot_alloc_bench.sv
module flow_slot_alloc_bench;
    localparam int IDX_W   = 8;
    localparam int DATA_W  = 32;
    localparam int TS_W    = 10;
    localparam int TS_IN_W = 16;
    localparam int N       = 1 << IDX_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [1:0]         cmd_op = 2'd0;
    logic [IDX_W-1:0]   cmd_hash = '0;
    logic [TS_IN_W-1:0] cmd_ts = '0;
    logic [1:0]         cmd_state = 2'd0;
    logic [DATA_W-1:0]  cmd_data = '0;
    logic               rsp_valid, rsp_ok, cache_clr, busy, glob_en;
    logic [IDX_W-1:0]   rsp_idx;
    logic [IDX_W-1:0]   lk_idx = '0;
    logic [TS_W+2:0]    lk_ctrl;
    logic [DATA_W-1:0]  lk_data;

    int checks = 0;
    int errors = 0;

    bit                m_static [N];
    logic [1:0]        m_state  [N];
    logic [TS_W-1:0]   m_ts     [N];
    logic [DATA_W-1:0] m_data   [N];

    always #5 clk = ~clk;

    flow_slot_alloc u_flow_slot_alloc (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_hash(cmd_hash), .cmd_ts(cmd_ts), .cmd_state(cmd_state),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_idx(rsp_idx),
        .cache_clr(cache_clr), .busy(busy), .glob_en(glob_en), .lk_idx(lk_idx),
        .lk_ctrl(lk_ctrl), .lk_data(lk_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_reserved(input int i);
        int off = i % 128;
        return (off == 12) || (off == 25) || (off == 38) || (off == 51) ||
               (off == 76) || (off == 89) || (off == 102);
    endfunction

    function automatic bit usable(input int i);
        return !m_static[i] && (m_state[i] != 2'd2);
    endfunction

    function automatic logic [TS_W+2:0] mctrl(input int i);
        return {m_static[i], m_state[i], m_ts[i]};
    endfunction

    task automatic compare_table(input string tag);
        int bad = 0;
        for (int i = 0; i < N; i++) begin
            lk_idx = IDX_W'(i);
            @(negedge clk);
            if (lk_ctrl !== mctrl(i) || lk_data !== m_data[i]) begin
                if (bad == 0) chk(1'b0, tag, {lk_ctrl, lk_data}, {mctrl(i), m_data[i]});
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, tag, 0, 0);
    endtask

    task automatic count_busy(input string tag);
        int cnt = 0;
        while (busy && cnt < 2 * N) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == N, tag, cnt, N);
    endtask

    task automatic model_init();
        for (int i = 0; i < N; i++) begin
            m_static[i] = is_reserved(i);
            m_state[i]  = 2'd0;
            m_ts[i]     = '0;
            m_data[i]   = '0;
        end
    endtask

    task automatic do_sweep(input logic [1:0] op, input string tag);
        chk(cmd_ready == 1'b1, {tag, " ready before sweep (R10)"}, cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op == 2'd1) chk(glob_en == 1'b0, "R9 enable cleared at accept", glob_en, 0);
        count_busy({tag, " sweep length"});
        if (op == 2'd1) begin
            for (int i = 0; i < N; i++) begin
                m_static[i] = 1'b0;
                m_state[i]  = 2'd0;
                m_ts[i]     = '0;
            end
            chk(glob_en == 1'b0, "R9 enable stays low", glob_en, 0);
        end else begin
            model_init();
            chk(glob_en == 1'b1, "R1 enable after init", glob_en, 1);
        end
        compare_table({tag, " table contents"});
    endtask

    task automatic do_commit(input int hash, input logic [15:0] ts, input logic [1:0] st,
                             input logic [31:0] dat, input bit spam, input string tag);
        int s1 = (hash + 1) % N;
        int exp_idx, lat, cyc, clr_cyc;
        bit exp_ok, busy_bad;
        logic [TS_W+2:0] old_ctrl;
        if (usable(hash)) begin
            exp_idx = hash; exp_ok = 1'b1; lat = 5;
        end else if (usable(s1)) begin
            exp_idx = s1; exp_ok = 1'b1; lat = 6;
        end else begin
            exp_idx = hash; exp_ok = 1'b0; lat = 3;
        end
        lk_idx    = IDX_W'(exp_idx);
        old_ctrl  = mctrl(exp_idx);
        chk(cmd_ready == 1'b1, {tag, " R10 ready when idle"}, cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_op    = 2'd0;
        cmd_hash  = IDX_W'(hash);
        cmd_ts    = ts;
        cmd_state = st;
        cmd_data  = dat;
        @(posedge clk);
        @(negedge clk);
        if (spam) cmd_op = 2'd1;
        else cmd_valid = 1'b0;
        cyc = 1; clr_cyc = 0; busy_bad = 1'b0;
        while (!rsp_valid && cyc < 20) begin
            if (!busy || cmd_ready) busy_bad = 1'b1;
            if (cache_clr) clr_cyc = cyc;
            if (exp_ok && cyc == lat - 2) begin
                chk(lk_data == dat, {tag, " R7 payload written first"}, lk_data, dat);
                chk(lk_ctrl == old_ctrl, {tag, " R7 control word still old"}, lk_ctrl, old_ctrl);
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0;
        chk(cyc == lat, {tag, exp_ok ? " R4 latency" : " R5 latency"}, cyc, lat);
        chk(rsp_ok == exp_ok, {tag, exp_ok ? " R4 status" : " R5 status"}, rsp_ok, exp_ok);
        chk(rsp_idx == IDX_W'(exp_idx), {tag, exp_ok ? " R4 index" : " R5 index"}, rsp_idx, exp_idx);
        chk(!busy_bad, {tag, " R10 busy and not ready"}, busy_bad, 0);
        chk(clr_cyc == (exp_ok ? lat - 1 : 0), {tag, " R8 cache clear timing"}, clr_cyc, exp_ok ? lat - 1 : 0);
        if (exp_ok) begin
            m_static[exp_idx] = 1'b0;
            m_state[exp_idx]  = st;
            m_ts[exp_idx]     = ts[TS_W-1:0];
            m_data[exp_idx]   = dat;
        end
        @(negedge clk);
        chk(!busy && cmd_ready, {tag, " R10 idle after response"}, busy, 0);
        chk(lk_ctrl == mctrl(exp_idx), {tag, exp_ok ? " R6 stored control" : " R5 control unchanged"},
            lk_ctrl, mctrl(exp_idx));
        chk(lk_data == m_data[exp_idx], {tag, exp_ok ? " R6 stored payload" : " R5 payload unchanged"},
            lk_data, m_data[exp_idx]);
        if (spam) chk(glob_en == 1'b1, {tag, " R10 held stop ignored"}, glob_en, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b1 && cmd_ready == 1'b0, "R10 reset state busy", {busy, cmd_ready}, 2'b10);
        chk(rsp_valid == 1'b0 && cache_clr == 1'b0, "R8 reset state quiet", {rsp_valid, cache_clr}, 0);
        chk(glob_en == 1'b0, "R1 reset enable low", glob_en, 0);
        rst_n = 1'b1;
        count_busy("R1 reset init length");
        model_init();
        chk(glob_en == 1'b1, "R1 enable after reset init", glob_en, 1);
        compare_table("R1 R2 table after reset");

        do_commit(5,   16'hFFFF, 2'd2, 32'hA0A0_0001, 1'b0, "hashed slot");
        do_commit(5,   16'h1234, 2'd2, 32'hA0A0_0002, 1'b0, "collision to next");
        do_commit(5,   16'h0001, 2'd2, 32'hA0A0_0003, 1'b0, "both bound");
        do_commit(11,  16'h0002, 2'd2, 32'hB0B0_0001, 1'b0, "before reserved");
        do_commit(11,  16'h0003, 2'd2, 32'hB0B0_0002, 1'b0, "R2 R3 reserved next slot");
        do_commit(12,  16'h0004, 2'd2, 32'hB0B0_0003, 1'b0, "R3 reserved hashed slot");
        do_commit(139, 16'h0005, 2'd2, 32'hC0C0_0001, 1'b0, "second group");
        do_commit(139, 16'h0006, 2'd2, 32'hC0C0_0002, 1'b0, "R2 second group reserved");
        do_commit(20,  16'h0007, 2'd1, 32'hD0D0_0001, 1'b0, "unbind entry");
        do_commit(20,  16'h0008, 2'd2, 32'hD0D0_0002, 1'b0, "R3 unbind overwritten");
        do_commit(20,  16'h0009, 2'd3, 32'hD0D0_0003, 1'b0, "fin to next");
        do_commit(21,  16'h000A, 2'd2, 32'hD0D0_0004, 1'b0, "R3 fin overwritten");
        do_commit(255, 16'h000B, 2'd2, 32'hE0E0_0001, 1'b0, "last slot");
        do_commit(255, 16'h000C, 2'd2, 32'hE0E0_0002, 1'b0, "R4 wrap to zero");
        do_commit(30,  16'h000D, 2'd2, 32'hF0F0_0001, 1'b1, "held request");

        do_sweep(2'd1, "R9 stop");
        do_commit(5,   16'h0100, 2'd2, 32'h1111_0001, 1'b0, "R9 after stop");
        do_commit(12,  16'h0101, 2'd2, 32'h1111_0002, 1'b0, "R9 static cleared");
        do_sweep(2'd2, "R1 R2 init command");
        do_commit(12,  16'h0102, 2'd2, 32'h1111_0003, 1'b0, "R2 reserved again");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule